// File: doc/BRIEF.md
# Trace Bit-Scan Display Sequencer

This block draws one stored digital trace on a vector display. On a start request it fetches bytes from shared memory over a simple request/grant DMA port. It reads a short header first and then the packed trace data. Each data byte is scanned one bit per cycle onto a vertical-level output. A horizontal position counter advances for every bit that is actually drawn, and a beam-enable output is driven by two preloaded counters.

The header holds three values. The first is the beam-on preload: when it has stepped up to all ones, the beam turns on. The second is the beam-off preload: when it has stepped up to all ones, the beam turns off. The third is the bit position in the first data byte where horizontal motion starts. The trace finishes at the end of the byte during which the beam went off. At that point a one-cycle completion pulse is raised and the block goes back to idle. When the memory grant is low, the whole sequencer holds still.

Top module: `traceScanDisplay`

## Requirements
- R1: In idle, a high `start` at a clock edge loads `dmaAddr` with `startAddr` and raises `dmaReq` in the next cycle. A `start` while a trace is running has no effect on any output.
- R2: The header is five bytes read at `startAddr`..`startAddr+4`. Bytes 0 and 1 are the beam-on preload (low byte first). Bytes 2 and 3 are the beam-off preload (low byte first). Bits 2:0 of byte 4 are the start bit. Data bytes follow from `startAddr+5`.
- R3: `dmaAddr` increments by one after each granted fetch and wraps modulo 4096.
- R4: `dmaReq` is high only while a header or data byte is wanted. A byte is taken in the cycle where `dmaReq` and `dmaGrant` are both high. `dmaReq` stays low while bits are being scanned.
- R5: Each byte is scanned least significant bit first, one bit per granted cycle. `yBit` shows the scanned bit from the edge at which that bit is scanned.
- R6: `xCount` clears at start and counts drawn bits. Bits of the first byte below the start bit are not drawn. Every bit from the start bit onward is drawn.
- R7: Both preloads step once per scanned bit and saturate at all ones. For the k-th scanned bit (k from 1), with preloads U and B, `zOn` = (U+k >= 65535) and (B+k < 65535). Off wins when both are reached on the same bit.
- R8: After the last bit of a byte, the next byte is fetched if the beam is still allowed. Otherwise `done` is high for exactly one cycle, `dmaReq` stays low, and the block returns to idle.
- R9: While `dmaGrant` is low during a trace, `dmaReq`, `dmaAddr`, `xCount`, `yBit`, `zOn` and `done` hold their values.
- R10: After reset, `dmaReq`, `dmaAddr`, `xCount`, `yBit`, `zOn` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a trace (honoured in idle only) |
| startAddr | input | 12 | Memory location of the trace header |
| dmaGrant | input | 1 | Memory slot granted; low stalls the sequencer |
| dmaData | input | 8 | Byte read from memory at `dmaAddr` |
| dmaReq | output | 1 | Byte fetch wanted |
| dmaAddr | output | 12 | Fetch address |
| xCount | output | 10 | Horizontal position (drawn-bit count) |
| yBit | output | 1 | Currently scanned trace bit |
| zOn | output | 1 | Beam enable |
| done | output | 1 | One-cycle trace completion pulse |

## Verification
The embedded properties hold on every cycle. They check that the beam only rises after the on-preload reaches all ones and only falls after the off-preload does, and that a saturated preload stays put. They also check that the horizontal count never moves by more than one step, that control state freezes without a grant, and that completion is a single-cycle pulse. The exact bit order, the header field layout, the start-bit gating of horizontal motion, address wrap, the per-bit beam window and the word on which the trace ends can only be shown by the directed scenarios. Those scenarios compare every scanned bit against values worked out from the preloads.

// File: rtl/traceScanPkg.sv
package traceScanPkg;
  // Width of one memory byte / trace word
  localparam int WORD_W     = 8;
  // Width of the beam preload counters
  localparam int CNT_W      = 16;
  localparam int CNT_BYTES  = CNT_W / WORD_W;
  localparam int HDR_BYTES  = 2 * CNT_BYTES + 1;
  localparam int BIT_IDX_W  = $clog2(WORD_W);
  localparam int HDR_IDX_W  = $clog2(HDR_BYTES);
  localparam int CNT_SEL_W  = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FETCH,
    ST_SCAN,
    ST_DONE
  } scanState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 clearAll;
    logic                 hdrTake;
    logic [HDR_IDX_W-1:0] hdrIdx;
    logic                 wordTake;
    logic                 scanStep;
    logic [BIT_IDX_W-1:0] bitIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/traceSatCounter.sv
module traceSatCounter #(
  parameter int W      = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = W / BYTE_W,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              byteWr,
  input  logic [SEL_W-1:0]  byteSel,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              step,
  output logic              hitsMax
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] value;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (clear) begin
      value <= '0;
    end else if (byteWr) begin
      value[int'(byteSel)*BYTE_W +: BYTE_W] <= byteData;
    end else if (step && (value != ALL_ONES)) begin
      value <= value + W'(1);
    end
  end

  // True on a step whose result is all ones
  assign hitsMax = step && ((value == ALL_ONES) || (value == ALL_ONES - W'(1)));

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (value == ALL_ONES) && !clear && !byteWr |=> (value == ALL_ONES));
endmodule

// File: rtl/traceCtrl.sv
module traceCtrl
  import traceScanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        dmaGrant,
  input  logic        offNow,
  output ctrlStrobe_t strobe,
  output logic        dmaReq,
  output logic        done
);
  scanState_t           state;
  logic [HDR_IDX_W-1:0] hdrIdx;
  logic [BIT_IDX_W-1:0] bitIdx;

  always_comb begin
    strobe          = '0;
    strobe.hdrIdx   = hdrIdx;
    strobe.bitIdx   = bitIdx;
    strobe.clearAll = (state == ST_IDLE) && start;
    strobe.hdrTake  = (state == ST_HDR) && dmaGrant;
    strobe.wordTake = (state == ST_FETCH) && dmaGrant;
    strobe.scanStep = (state == ST_SCAN) && dmaGrant;
  end

  assign dmaReq = (state == ST_HDR) || (state == ST_FETCH);
  assign done   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrIdx <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_HDR;
          hdrIdx <= '0;
        end
        ST_HDR: if (dmaGrant) begin
          if (hdrIdx == HDR_IDX_W'(HDR_BYTES - 1)) state <= ST_FETCH;
          else hdrIdx <= hdrIdx + HDR_IDX_W'(1);
        end
        ST_FETCH: if (dmaGrant) begin
          state  <= ST_SCAN;
          bitIdx <= '0;
        end
        ST_SCAN: if (dmaGrant) begin
          if (bitIdx == BIT_IDX_W'(WORD_W - 1)) state <= offNow ? ST_DONE : ST_FETCH;
          else bitIdx <= bitIdx + BIT_IDX_W'(1);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_stall_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dmaGrant && ((state == ST_HDR) || (state == ST_FETCH) || (state == ST_SCAN))
    |=> $stable(state) && $stable(bitIdx) && $stable(hdrIdx));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_scan_no_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scanStep |-> !dmaReq);
endmodule

// File: rtl/traceDatapath.sv
module traceDatapath
  import traceScanPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int X_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [WORD_W-1:0] dmaData,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [X_W-1:0]    xCount,
  output logic              yBit,
  output logic              zOn,
  output logic              offNow
);
  localparam int N_CNT = 2;   // 0: beam-on preload, 1: beam-off preload

  logic [WORD_W-1:0]    wordReg;
  logic [BIT_IDX_W-1:0] startBit;
  logic                 sweepOn;
  logic                 offLatched;
  logic                 cntWr  [N_CNT];
  logic [CNT_SEL_W-1:0] cntSel [N_CNT];
  logic                 cntHit [N_CNT];
  logic                 curBit;
  logic                 showBit;
  logic                 sbWr;

  // Header byte routing
  for (genvar g = 0; g < N_CNT; g++) begin : gCnt
    assign cntWr[g]  = strobe.hdrTake &&
                       (int'(strobe.hdrIdx) >= g * CNT_BYTES) &&
                       (int'(strobe.hdrIdx) < (g + 1) * CNT_BYTES);
    assign cntSel[g] = CNT_SEL_W'(int'(strobe.hdrIdx) - g * CNT_BYTES);

    traceSatCounter #(.W(CNT_W), .BYTE_W(WORD_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (strobe.clearAll),
      .byteWr   (cntWr[g]),
      .byteSel  (cntSel[g]),
      .byteData (dmaData),
      .step     (strobe.scanStep),
      .hitsMax  (cntHit[g])
    );
  end

  assign sbWr    = strobe.hdrTake && (int'(strobe.hdrIdx) == 2 * CNT_BYTES);
  assign curBit  = wordReg[strobe.bitIdx];
  assign showBit = sweepOn || (strobe.bitIdx == startBit);
  assign offNow  = offLatched || cntHit[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaAddr <= '0;
    end else if (strobe.clearAll) begin
      dmaAddr <= startAddr;
    end else if (strobe.hdrTake || strobe.wordTake) begin
      dmaAddr <= dmaAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      startBit <= '0;
    end else if (strobe.clearAll) begin
      wordReg  <= '0;
      startBit <= '0;
    end else begin
      if (sbWr)            startBit <= dmaData[BIT_IDX_W-1:0];
      if (strobe.wordTake) wordReg  <= dmaData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCount     <= '0;
      yBit       <= 1'b0;
      zOn        <= 1'b0;
      sweepOn    <= 1'b0;
      offLatched <= 1'b0;
    end else if (strobe.clearAll) begin
      xCount     <= '0;
      yBit       <= 1'b0;
      zOn        <= 1'b0;
      sweepOn    <= 1'b0;
      offLatched <= 1'b0;
    end else if (strobe.scanStep) begin
      yBit <= curBit;
      if (showBit) begin
        sweepOn <= 1'b1;
        xCount  <= xCount + X_W'(1);
      end
      if (offNow) begin
        zOn        <= 1'b0;
        offLatched <= 1'b1;
      end else if (cntHit[0]) begin
        zOn <= 1'b1;
      end
    end
  end

  assert_beam_on_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zOn) |-> $past(cntHit[0]));

  assert_beam_off_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zOn) |-> $past(cntHit[1] || strobe.clearAll));

  assert_x_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearAll |=> (xCount == $past(xCount)) || (xCount == $past(xCount) + X_W'(1)));
endmodule

// File: rtl/traceScanDisplay.sv
module traceScanDisplay
  import traceScanPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int X_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dmaGrant,
  input  logic [WORD_W-1:0] dmaData,
  output logic              dmaReq,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [X_W-1:0]    xCount,
  output logic              yBit,
  output logic              zOn,
  output logic              done
);
  ctrlStrobe_t strobe;
  logic        offNow;

  traceCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .dmaGrant (dmaGrant),
    .offNow   (offNow),
    .strobe   (strobe),
    .dmaReq   (dmaReq),
    .done     (done)
  );

  traceDatapath #(.ADDR_W(ADDR_W), .X_W(X_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .dmaData   (dmaData),
    .dmaAddr   (dmaAddr),
    .xCount    (xCount),
    .yBit      (yBit),
    .zOn       (zOn),
    .offNow    (offNow)
  );
endmodule

// File: tb/traceScanDisplay_bench.sv
module traceScanDisplay_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] startAddr = '0;
  logic        dmaGrant = 1'b0;
  logic [7:0]  dmaData;
  logic        dmaReq;
  logic [11:0] dmaAddr;
  logic [9:0]  xCount;
  logic        yBit;
  logic        zOn;
  logic        done;

  logic [7:0] mem [256];
  logic [7:0] wordVals [16];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5ns clk = ~clk;

  assign dmaData = mem[dmaAddr[7:0]];

  traceScanDisplay u_traceScanDisplay (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .dmaGrant(dmaGrant), .dmaData(dmaData), .dmaReq(dmaReq),
    .dmaAddr(dmaAddr), .xCount(xCount), .yBit(yBit), .zOn(zOn), .done(done)
  );

  task automatic chk(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic testReset();
    chk("R10", "dmaReq", int'(dmaReq), 0);
    chk("R10", "dmaAddr", int'(dmaAddr), 0);
    chk("R10", "xCount", int'(xCount), 0);
    chk("R10", "yBit", int'(yBit), 0);
    chk("R10", "zOn", int'(zOn), 0);
    chk("R10", "done", int'(done), 0);
  endtask

  // One complete trace, every op checked against values derived from R2..R9
  task automatic runTrace(input logic [11:0] sa, input int U, input int B,
                          input int sb, input int nStall, input bit noise, input int seed);
    int kOff;
    int nWords;
    int k;
    kOff   = (B >= 65535) ? 1 : 65535 - B;
    nWords = (kOff + 7) / 8;
    mem[(int'(sa) + 0) & 255] = 8'(U & 255);
    mem[(int'(sa) + 1) & 255] = 8'((U >> 8) & 255);
    mem[(int'(sa) + 2) & 255] = 8'(B & 255);
    mem[(int'(sa) + 3) & 255] = 8'((B >> 8) & 255);
    mem[(int'(sa) + 4) & 255] = 8'(sb);
    for (int w = 0; w < nWords; w++) begin
      wordVals[w] = 8'((seed * 73 + w * 29 + 5) & 255);
      mem[(int'(sa) + 5 + w) & 255] = wordVals[w];
    end
    @(negedge clk);
    startAddr = sa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "dmaReq after start", int'(dmaReq), 1);
    chk("R1", "dmaAddr after start", int'(dmaAddr), int'(sa));
    k = 0;
    for (int op = 0; op < 5 + nWords * 9; op++) begin
      bit isFetch;
      int addrExp;
      int w;
      int b;
      w = 0;
      b = 0;
      if (op < 5) begin
        isFetch = 1'b1;
        addrExp = (int'(sa) + op) & 4095;
      end else begin
        w = (op - 5) / 9;
        b = (op - 5) % 9 - 1;
        isFetch = (b < 0);
        addrExp = (int'(sa) + 5 + w) & 4095;
      end
      if (nStall > 0 && (op % 3) == 1) begin
        for (int s = 0; s < nStall; s++) begin
          logic        pReq;
          logic [11:0] pAddr;
          logic [9:0]  pX;
          logic        pY;
          logic        pZ;
          dmaGrant = 1'b0;
          pReq = dmaReq; pAddr = dmaAddr; pX = xCount; pY = yBit; pZ = zOn;
          @(negedge clk);
          chk("R9", "stall dmaReq", int'(dmaReq), int'(pReq));
          chk("R9", "stall dmaAddr", int'(dmaAddr), int'(pAddr));
          chk("R9", "stall xCount", int'(xCount), int'(pX));
          chk("R9", "stall yBit", int'(yBit), int'(pY));
          chk("R9", "stall zOn", int'(zOn), int'(pZ));
          chk("R9", "stall done", int'(done), 0);
        end
      end
      dmaGrant = 1'b1;
      chk("R4", "dmaReq per phase", int'(dmaReq), int'(isFetch));
      if (isFetch) begin
        if (op < 5) chk("R2", "header address", int'(dmaAddr), addrExp);
        else        chk("R3", "data address", int'(dmaAddr), addrExp);
      end
      if (noise && op == 8) start = 1'b1;  // R1: ignored while busy
      @(negedge clk);
      start = 1'b0;
      dmaGrant = 1'b0;
      if (!isFetch) begin
        int xExp;
        int zExp;
        k++;
        xExp = (k > sb) ? k - sb : 0;
        zExp = ((U + k) >= 65535 && (B + k) < 65535) ? 1 : 0;
        chk("R5", "yBit", int'(yBit), int'(wordVals[w][b]));
        chk("R6", "xCount", int'(xCount), xExp);
        chk("R7", "zOn", int'(zOn), zExp);
      end
    end
    chk("R8", "done at end", int'(done), 1);
    chk("R8", "no request at end", int'(dmaReq), 0);
    @(negedge clk);
    chk("R8", "done single cycle", int'(done), 0);
    chk("R8", "idle no request", int'(dmaReq), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R6 R7 basic: beam on from bit 15, off at bit 31, start bit 3
    runTrace(12'h010, 32'hFFF0, 32'hFFE0, 3, 0, 1'b0, 1);
    // R9 stalls, beam on from first bit, start bit 0
    runTrace(12'h020, 32'hFFFF, 32'hFFF5, 0, 2, 1'b0, 2);
    // R1 start while busy, start bit 7, beam never on, single word
    runTrace(12'h040, 32'h0000, 32'hFFFC, 7, 0, 1'b1, 3);
    // R3 address wrap across 4095
    runTrace(12'hFFC, 32'hFFF8, 32'hFFEE, 5, 1, 1'b0, 4);
    // R7 both preloads reach all ones on the same bit: off wins
    runTrace(12'h060, 32'hFFF0, 32'hFFF0, 2, 0, 1'b0, 5);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule